// File: doc/BRIEF.md
# Programmable Down-Counter Digitally Controlled Oscillator

This block is a digitally controlled oscillator for an all-digital phase-locked loop. It runs on a fast counter clock and divides that clock by a number the loop filter sets. A loadable down-counter decrements on every counter-clock edge. A terminal-count detector spots the edge on which the count would fall to zero. On that edge the block raises an output pulse and reloads the counter with `M - K`. Here `M` is a build-time parameter and `K` is the control word from the loop filter. A larger `K` gives a shorter period and a higher output frequency. With `K = 0` the block free-runs at the counter clock divided by `M`.

`K` is sampled only on the reload edge, so each output period is set by the control word present at the start of that period. The reload value is held to the range 1 to `2^CNT_W - 1`. A `K` at or above `M` therefore cannot stall the oscillator, and a large negative `K` (in signed mode) cannot overflow the counter. A square wave that toggles on every pulse gives a 50% duty output at half the pulse rate.

A two-state controller sequences the block. In `ST_COUNT` the counter decrements. The transition `COUNT_TO_FIRE` is taken when the terminal count is seen; on that edge the counter reloads. `ST_FIRE` is the pulse cycle. From `ST_FIRE` the controller takes `FIRE_TO_COUNT` when the freshly loaded count is above 1. It takes `FIRE_TO_FIRE` when the reload value is 1, which gives a pulse on every cycle.

Top module: `dco_divk`

## Requirements
- R1: While reset is low, `pulse_o` and `square_o` are 0 and the counter holds `M`. After reset is released, the first pulse appears on the M-th rising clock edge.
- R2: When the period in force is 2 or more, `pulse_o` is high for exactly one clock cycle per period.
- R3: The number of clock cycles from one pulse to the next equals `M - K`, where `K` is the control word sampled on the edge that produced the first of the two pulses. In signed mode (`K_SIGNED = 1`), `K` is two's complement of width `K_W`; a negative `K` lengthens the period.
- R4: With `K = 0`, the pulse period is exactly `M` clock cycles.
- R5: A change of `k_i` between reload edges has no effect on the period already running. Only the value present on the reload edge counts.
- R6: When `M - K` is less than 1, the period is 1 cycle, so `pulse_o` stays high on every cycle.
- R7: When `M - K` exceeds `2^CNT_W - 1`, the period is `2^CNT_W - 1` cycles.
- R8: `square_o` changes value on every edge that raises a pulse and on no other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_i | input | K_W | Frequency control word from the loop filter |
| pulse_o | output | 1 | One-cycle output pulse at each terminal count |
| square_o | output | 1 | Square wave at half the pulse rate |

## Verification
The control word is stepped through several patterns, and each one separates a different failure.

- A zero word checks the free-running divide by `M`.
- Small positive and negative words show whether the reload subtracts `K` with the right sign.
- Words at and beyond `M` separate a correct floor of 1 from a wrap or stall.
- Strongly negative words show whether the ceiling clamp holds or the count truncates.
- A word that changes for a few cycles in mid-period and then returns shows whether `K` is sampled only on the reload edge or leaks into the running period.

Every measured period is compared against a queue of expected periods, and the square-wave level is checked at every pulse.

// File: rtl/dco_pkg.sv
package dco_pkg;

    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_FIRE  = 1'b1
    } dco_state_e;

    function automatic int dco_max_period(input int cnt_w);
        return (1 << cnt_w) - 1;
    endfunction

endpackage

// File: rtl/dco_reload_calc.sv
module dco_reload_calc #(
    parameter int M        = 100,
    parameter int CNT_W    = 8,
    parameter int K_W      = 8,
    parameter bit K_SIGNED = 1'b1
) (
    input  logic [K_W-1:0]   k_i,
    output logic [CNT_W-1:0] reload_o
);
    localparam int CALC_W = ((CNT_W > K_W) ? CNT_W : K_W) + 2;
    localparam int RMAX   = dco_pkg::dco_max_period(CNT_W);
    localparam logic signed [CALC_W-1:0] M_EXT   = CALC_W'(M);
    localparam logic signed [CALC_W-1:0] LIM_LO  = CALC_W'(1);
    localparam logic signed [CALC_W-1:0] LIM_HI  = CALC_W'(RMAX);

    logic signed [CALC_W-1:0] k_ext;
    logic signed [CALC_W-1:0] diff;

    generate
        if (K_SIGNED) begin : g_signed_k
            assign k_ext = {{(CALC_W-K_W){k_i[K_W-1]}}, k_i};
        end else begin : g_unsigned_k
            assign k_ext = {{(CALC_W-K_W){1'b0}}, k_i};
        end
    endgenerate

    assign diff = M_EXT - k_ext;

    always_comb begin
        if (diff < LIM_LO) begin
            reload_o = CNT_W'(1);
        end else if (diff > LIM_HI) begin
            reload_o = CNT_W'(RMAX);
        end else begin
            reload_o = diff[CNT_W-1:0];
        end
    end

    // R6 / R7: the reload value always lies in 1 .. 2^CNT_W-1
    always_comb begin
        p_reload_range_r7: assert (reload_o != '0);
    end

endmodule

// File: rtl/dco_down_counter.sv
module dco_down_counter #(
    parameter int M     = 100,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             term_o
);
    localparam logic [CNT_W-1:0] M_INIT = CNT_W'(M);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= M_INIT;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // the next decrement would reach zero
    assign term_o = (cnt_q == ONE);
    assign cnt_o  = cnt_q;

    // R1: first cycle out of reset starts from M
    p_reset_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cnt_q == M_INIT);

    // R3: a reload takes the value offered on that edge
    p_reload_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(reload_i));

    // R3: otherwise the count steps down by one
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> cnt_q == $past(cnt_q) - ONE);

    // R6: the count never sits at zero
    p_never_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

endmodule

// File: rtl/dco_ctrl_fsm.sv
module dco_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic term_i,
    output logic load_o,
    output logic pulse_o
);
    import dco_pkg::*;

    dco_state_e state_q;
    dco_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (term_i) state_d = ST_FIRE;   // COUNT_TO_FIRE
            ST_FIRE:  if (term_i) state_d = ST_FIRE;   // FIRE_TO_FIRE
                      else        state_d = ST_COUNT;  // FIRE_TO_COUNT
            default:  state_d = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_o  = term_i;
        pulse_o = (state_q == ST_FIRE);
    end

    // R3: a terminal count is always followed by the pulse cycle
    p_term_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        term_i |=> pulse_o);

endmodule

// File: rtl/dco_square_div.sv
module dco_square_div (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic sq_o
);
    logic sq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= 1'b0;
        end else if (fire_i) begin
            sq_q <= ~sq_q;
        end
    end

    assign sq_o = sq_q;

endmodule

// File: rtl/dco_divk.sv
module dco_divk #(
    parameter int M        = 100,
    parameter int CNT_W    = 8,
    parameter int K_W      = 8,
    parameter bit K_SIGNED = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [K_W-1:0] k_i,
    output logic           pulse_o,
    output logic           square_o
);
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             term_w;
    logic             load_w;

    dco_reload_calc #(
        .M        (M),
        .CNT_W    (CNT_W),
        .K_W      (K_W),
        .K_SIGNED (K_SIGNED)
    ) u_calc (
        .k_i      (k_i),
        .reload_o (reload_w)
    );

    dco_down_counter #(
        .M     (M),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .reload_i (reload_w),
        .cnt_o    (cnt_w),
        .term_o   (term_w)
    );

    dco_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .term_i  (term_w),
        .load_o  (load_w),
        .pulse_o (pulse_o)
    );

    dco_square_div u_sq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (load_w),
        .sq_o   (square_o)
    );

    // R2: with a loaded count above 1 the pulse lasts one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && cnt_w != CNT_W'(1)) |=> !pulse_o);

    // R8: the square wave changes exactly when a pulse is raised
    p_sq_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> square_o != $past(square_o));

    p_sq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> $stable(square_o));

endmodule

// File: tb/tb_dco_divk.sv
module tb_dco_divk;
    localparam int CLK_P = 10;
    localparam int M     = 20;
    localparam int CNT_W = 5;
    localparam int K_W   = 6;
    localparam int RMAX  = 31;

    typedef struct {
        int    period;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [K_W-1:0] k_i = '0;
    logic           pulse_o;
    logic           square_o;

    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;
    exp_t expq[$];
    int   last_push;

    always #(CLK_P/2) clk = ~clk;

    dco_divk #(.M(M), .CNT_W(CNT_W), .K_W(K_W), .K_SIGNED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .k_i(k_i),
        .pulse_o(pulse_o), .square_o(square_o)
    );

    function automatic int exp_period(input int kv);
        int r;
        r = M - kv;
        if (r < 1) r = 1;
        if (r > RMAX) r = RMAX;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push_exp(input int p, input string tag);
        exp_t e;
        e.period = p;
        e.tag    = tag;
        expq.push_back(e);
        last_push = p;
    endtask

    // wait for a pulse, then present a new word for the next reload edge
    task automatic step(input int kv, input string tag, input bit glitch);
        do @(negedge clk); while (!pulse_o);
        if (glitch && last_push >= 4) begin
            k_i = K_W'(M + 5);
            @(negedge clk);
            k_i = K_W'(-M);
            @(negedge clk);
        end
        k_i = K_W'(kv);
        push_exp(exp_period(kv), tag);
    endtask

    // monitor
    initial begin
        int cyc;
        int last;
        bit sq_exp;
        cyc = 0;
        last = 0;
        sq_exp = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            if (pulse_o) begin
                exp_t e;
                if (expq.size() == 0) begin
                    check(1'b0, "R3 queue", cyc - last, 0);
                end else begin
                    e = expq.pop_front();
                    check(cyc - last == e.period, e.tag, cyc - last, e.period);
                end
                sq_exp = ~sq_exp;
                check(square_o == sq_exp, "R8", int'(square_o), int'(sq_exp));
                last = cyc;
            end else if (!done && cyc - last > 100) begin
                check(1'b0, "R3 watchdog", cyc - last, 0);
                last = cyc;
            end
        end
    end

    // overall watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // driver
    initial begin
        k_i = K_W'(0);
        repeat (4) begin
            @(negedge clk);
            check(pulse_o == 1'b0, "R1 pulse", int'(pulse_o), 0);
            check(square_o == 1'b0, "R1 square", int'(square_o), 0);
        end
        push_exp(M, "R1");
        push_exp(exp_period(0), "R4");
        rst_n = 1'b1;
        step(0, "R4", 1'b0);
        step(5, "R3", 1'b0);
        step(5, "R3", 1'b0);
        step(-7, "R3", 1'b0);
        step(19, "R6", 1'b0);
        step(20, "R6", 1'b0);
        step(25, "R6", 1'b0);
        step(25, "R6", 1'b0);
        step(-11, "R7", 1'b0);
        step(-20, "R7", 1'b0);
        step(-32, "R7", 1'b0);
        step(3, "R5", 1'b1);
        step(3, "R5", 1'b1);
        step(0, "R4", 1'b0);
        for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
        check(expq.size() == 0, "R3 drain", expq.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule